// File: doc/BRIEF.md
# Clock Synthesizer Configuration Target

This block is the two-wire serial target that holds the configuration bytes of a programmable clock synthesizer. A host reaches it at 7-bit address 0x69, which is 0xD2 on the wire for writes and 0xD3 for reads. Through it the host writes clock-enable masks, frequency selection, divider and spread settings. It reads the same bytes back, mixed with live status from the core: latched strap pins, the watchdog down-count and the watchdog expiry flag. The stored bytes go to the clock core as one flat parallel bus. Identity bytes are constants that appear only on reads.

SCL and SDA are sampled by a faster system clock. Each line passes through a two-flop synchronizer and a persistence filter. Start and stop conditions are then detected from the filtered lines. SDA is driven open-drain, through an active-high pull-low enable. The command byte selects the transfer mode. Command 0x00 selects a block transfer over the whole register file, starting at register 0. A command with bit 7 set selects a single-register transfer, with the register index in bits 6:0. Any other command is refused with a NACK.

The protocol engine has six states:
- IDLE waits for a start condition.
- ADDR receives the address byte.
- CMD receives the command byte.
- COUNT takes the byte count of a block write.
- WDATA receives register data.
- RDATA shifts read data out.

Its transitions are:
- Start: any state goes to ADDR.
- Stop: any state goes to IDLE.
- ADDR→CMD on a write address that matches.
- ADDR→RDATA on a read address that matches.
- ADDR→IDLE on an address that does not match.
- CMD→COUNT on command 0x00.
- CMD→WDATA on a single-register command.
- CMD→IDLE on a refused command.
- COUNT→WDATA.
- WDATA→WDATA after each byte.
- RDATA→RDATA when the host ACKs.
- RDATA→IDLE when the host NACKs.

Top module: `clkcfg_smb_target`

## Requirements
- R1: The target ACKs only the address byte 0xD2 (write) or 0xD3 (read). Any other address is NACKed, and the following bytes of that transfer are neither ACKed nor stored.
- R2: A single-register write is address 0xD2, command 0x80|idx, then one data byte. It stores the writable bits of register idx. The result appears on cfg_regs bits [idx*8+7:idx*8], and a single-register read returns it. That read is 0xD2, command 0x80|idx, a repeated start, 0xD3, then one byte NACKed by the host.
- R3: A block write with command 0x00 is followed by a byte count, which is ACKed and otherwise unused. The data bytes that follow land in registers 0, 1, 2 and onward, one per byte.
- R4: A block read is 0xD2, command 0x00, a repeated start, then 0xD3. It returns the register count (15) first, then registers 0, 1, 2 and onward in order.
- R5: A command byte with bit 7 clear and a value other than 0x00 is NACKed, and no register changes.
- R6: After reset the stored bytes for registers 0 to 14 are 00, E0, 7F, F7, FF, 00, 08, 40, 00, 1F, 04, 00, 00, 00, 04. SDA is released.
- R7: Register 11 reads 0x32 and register 12 reads 0x11. Writes to either are ACKed and change nothing.
- R8: Reading register 1 returns strap_fs in bits 4:0. Reading register 2 returns strap_cur in bit 7. Written values for those bits are dropped.
- R9: Reading register 6 returns the live wd_count, while a write to register 6 stores the reload byte on cfg_regs. Reading register 5 returns wd_expired in bit 5. This holds even when wd_count changes in the same cycle the write lands.
- R10: A pulse on SCL shorter than FILT_LEN system clocks is ignored.
- R11: The target changes its SDA pull-down only while SCL is low.
- R12: A write to a register index of 15 or above is ACKed and ignored. A read of such an index returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_fs | input | 5 | Latched frequency-select straps, read in register 1 |
| strap_cur | input | 1 | Latched current-mode strap, read in register 2 bit 7 |
| wd_count | input | 8 | Live watchdog down-count, read in register 6 |
| wd_expired | input | 1 | Watchdog expiry flag, read in register 5 bit 5 |
| cfg_regs | output | 120 | Stored register bytes, register k in bits [k*8+7:k*8] |

## Verification
The write strobe into register 6 and a change of the live wd_count input can fall in the same system cycle. The bench provokes this by writing register 6 repeatedly while moving the wd_count update through every cycle offset of the low phase after the last data bit, which is where the strobe lands. For every offset the stored reload byte on cfg_regs must equal the written value, and a following read must return the new count rather than the written byte.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int NREG = 15;
    localparam int IDXW = 7;
    localparam logic [6:0] DEV_ADDR = 7'h69;
    localparam logic [7:0] ID_MAIN = 8'h32;
    localparam logic [7:0] ID_SUB = 8'h11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA, ST_RDATA
    } smb_state_e;

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            1:       return 8'hE0;
            2:       return 8'h7F;
            3:       return 8'hF7;
            4:       return 8'hFF;
            6:       return 8'h08;
            7:       return 8'h40;
            9:       return 8'h1F;
            10:      return 8'h04;
            14:      return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            1:       return 8'hE0;
            2:       return 8'h7F;
            5:       return 8'hDF;
            11, 12:  return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            flt_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            if (sync_q[1] != flt_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    flt_q <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign line_out = flt_q;

    AST_FILT_RISE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_q) |-> $past(sync_q[1])); // R10
    AST_FILT_FALL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_q) |-> !$past(sync_q[1])); // R10
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int N  = NREG,
    parameter int AW = IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    input  logic [4:0]    strap_fs,
    input  logic          strap_cur,
    input  logic [7:0]    wd_count,
    input  logic          wd_expired,
    output logic [N*8-1:0] cfg_regs
);
    localparam int SW = $clog2(N);

    logic [7:0] store [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                store[g] <= reg_reset(g);
            else if (wr_en && wr_idx == AW'(g))
                store[g] <= (store[g] & ~reg_wmask(g)) | (wr_data & reg_wmask(g));
        end
        assign cfg_regs[g*8 +: 8] = store[g];
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_idx < AW'(N)) begin
            rd_data = store[rd_idx[SW-1:0]];
            case (rd_idx)
                AW'(1):  rd_data = {store[1][7:5], strap_fs};
                AW'(2):  rd_data = {strap_cur, store[2][6:0]};
                AW'(5):  rd_data = {store[5][7:6], wd_expired, store[5][4:0]};
                AW'(6):  rd_data = wd_count;
                AW'(11): rd_data = ID_MAIN;
                AW'(12): rd_data = ID_SUB;
                default: ;
            endcase
        end
    end

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= AW'(N)) |=> $stable(cfg_regs)); // R12
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import clkcfg_pkg::*;
#(
    parameter int N  = NREG,
    parameter int AW = IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_idx
);
    smb_state_e    state_q, state_d;
    logic          scl_d, sda_d;
    logic [3:0]    bit_q;
    logic [7:0]    sh_q, tx_q, wdat_q;
    logic [AW-1:0] ptr_q, widx_q;
    logic          rw_q, ack_q, cnt_pend_q, mnack_q, oe_q, wr_q;
    logic          scl_rise, scl_fall, start_ev, stop_ev, rx_state, ack_now;
    logic [7:0]    tx_next;

    assign scl_rise = scl & ~scl_d;
    assign scl_fall = ~scl & scl_d;
    assign start_ev = scl & scl_d & sda_d & ~sda;
    assign stop_ev  = scl & scl_d & ~sda_d & sda;

    always_comb begin
        rx_state = state_q inside {ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA};
        unique case (state_q)
            ST_ADDR: ack_now = (sh_q[7:1] == DEV_ADDR);
            ST_CMD:  ack_now = sh_q[7] || (sh_q == 8'h00);
            default: ack_now = 1'b1;
        endcase
        tx_next = cnt_pend_q ? 8'(N) : rd_data;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (scl_fall && bit_q == 4'd9) begin
            unique case (state_q)
                ST_ADDR:  state_d = !ack_q ? ST_IDLE : (rw_q ? ST_RDATA : ST_CMD);
                ST_CMD:   state_d = !ack_q ? ST_IDLE : ((sh_q == 8'h00) ? ST_COUNT : ST_WDATA);
                ST_COUNT: state_d = ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = mnack_q ? ST_IDLE : ST_RDATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;  sda_d <= 1'b1;  bit_q <= '0;
            sh_q <= '0;     tx_q <= '0;     wdat_q <= '0;
            ptr_q <= '0;    widx_q <= '0;   rw_q <= 1'b0;
            ack_q <= 1'b0;  cnt_pend_q <= 1'b0;
            mnack_q <= 1'b0; oe_q <= 1'b0;  wr_q <= 1'b0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            wr_q  <= 1'b0;
            if (start_ev || stop_ev) begin
                bit_q <= '0;
                oe_q  <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && bit_q < 4'd8) begin
                    sh_q  <= {sh_q[6:0], sda};
                    bit_q <= bit_q + 1'b1;
                end else if (scl_fall && bit_q == 4'd8) begin
                    bit_q <= 4'd9;
                    oe_q  <= ack_now;
                    ack_q <= ack_now;
                    if (state_q == ST_ADDR) rw_q <= sh_q[0];
                    if (state_q == ST_CMD) begin
                        cnt_pend_q <= (sh_q == 8'h00);
                        ptr_q      <= (sh_q == 8'h00) ? '0 : sh_q[AW-1:0];
                    end
                    if (state_q == ST_WDATA) begin
                        wr_q   <= 1'b1;
                        wdat_q <= sh_q;
                        widx_q <= ptr_q;
                        ptr_q  <= ptr_q + 1'b1;
                    end
                end else if (scl_fall && bit_q == 4'd9) begin
                    bit_q <= '0;
                    oe_q  <= 1'b0;
                    if (state_q == ST_ADDR && ack_q && rw_q) begin
                        tx_q <= tx_next;
                        oe_q <= ~tx_next[7];
                        if (cnt_pend_q) cnt_pend_q <= 1'b0;
                        else            ptr_q <= ptr_q + 1'b1;
                    end
                end
            end else if (state_q == ST_RDATA) begin
                if (scl_rise) begin
                    if (bit_q == 4'd8) begin
                        mnack_q <= sda;
                        bit_q   <= 4'd9;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (bit_q < 4'd8) begin
                        tx_q <= {tx_q[6:0], 1'b0};
                        oe_q <= ~tx_q[6];
                    end else if (bit_q == 4'd8) begin
                        oe_q <= 1'b0;
                    end else begin
                        bit_q <= '0;
                        oe_q  <= 1'b0;
                        if (!mnack_q) begin
                            tx_q <= tx_next;
                            oe_q <= ~tx_next[7];
                            if (cnt_pend_q) cnt_pend_q <= 1'b0;
                            else            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_q;
    assign wr_idx  = widx_q;
    assign wr_data = wdat_q;
    assign rd_idx  = ptr_q;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> !scl); // R11
    AST_BLOCK_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COUNT) |-> ($past(sh_q) == 8'h00)); // R3
    AST_WRITE_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (state_q == ST_WDATA && bit_q == 4'd9)); // R2
endmodule

// File: rtl/clkcfg_smb_target.sv
module clkcfg_smb_target
    import clkcfg_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    input  logic [4:0]      strap_fs,
    input  logic            strap_cur,
    input  logic [7:0]      wd_count,
    input  logic            wd_expired,
    output logic [NREG*8-1:0] cfg_regs
);
    logic [1:0]      raw_l, flt_l;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx;
    logic [7:0]      wr_data, rd_data;

    assign raw_l = {scl_in, sda_in};

    for (genvar i = 0; i < 2; i++) begin : g_flt
        smb_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_l[i]),
            .line_out (flt_l[i])
        );
    end

    smb_target_fsm #(.N(NREG), .AW(IDXW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (flt_l[1]),
        .sda     (flt_l[0]),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx)
    );

    clkcfg_regfile #(.N(NREG), .AW(IDXW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .strap_fs   (strap_fs),
        .strap_cur  (strap_cur),
        .wd_count   (wd_count),
        .wd_expired (wd_expired),
        .cfg_regs   (cfg_regs)
    );
endmodule

// File: tb/clkcfg_smb_target_test.sv
module clkcfg_smb_target_test;
    localparam int Q = 12;
    localparam int NR = 15;

    // {index, written byte, expected read, expected stored}
    localparam logic [31:0] VEC [11] = '{
        32'h00A5A5A5, 32'h01FFF5E0, 32'h02008000, 32'h033C3C3C,
        32'h06559A55, 32'h0B003200, 32'h0CFF1100, 32'h0D7E7E7E,
        32'h05FFDFDF, 32'h14ABFF00, 32'h09C3C3C3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [4:0] strap_fs = 5'h15;
    logic strap_cur = 1'b1;
    logic [7:0] wd_count = 8'h9A;
    logic wd_expired = 1'b0;
    logic [NR*8-1:0] cfg;
    int checks = 0;
    int failures = 0;
    int viol = 0;
    logic oe_prev = 1'b0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    clkcfg_smb_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .strap_cur(strap_cur), .wd_count(wd_count),
        .wd_expired(wd_expired), .cfg_regs(cfg)
    );

    // R11 monitor: pull-down may only change while SCL is low
    always @(posedge clk) begin
        #1;
        if (rst_n && sda_oe !== oe_prev && scl === 1'b1) viol++;
        oe_prev = sda_oe;
    end

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, input int hook,
                             input logic [7:0] hv, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q); scl = 1'b1;
            if (glitch && i == 3) begin
                tick(4); scl = 1'b0; tick(2); scl = 1'b1; tick(2*Q - 6);
            end else begin
                tick(2*Q);
            end
            scl = 1'b0;
            for (int c = 0; c < Q; c++) begin
                if (i == 0 && c == hook) wd_count = hv;
                tick(1);
            end
        end
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        ack = !sda_bus;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
        end
        m_sda = nack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, input bit glitch,
                             input int hook, input logic [7:0] hv, output bit ok);
        bit a1, a2, a3;
        bus_start;
        send_byte(8'hD2, 0, -1, 8'h00, a1);
        send_byte(8'h80 | idx, 0, -1, 8'h00, a2);
        send_byte(d, glitch, hook, hv, a3);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        bit a;
        bus_start;
        send_byte(8'hD2, 0, -1, 8'h00, a);
        send_byte(8'h80 | idx, 0, -1, 8'h00, a);
        bus_start;
        send_byte(8'hD3, 0, -1, 8'h00, a);
        recv_byte(1'b1, d);
        bus_stop;
    endtask

    function automatic logic [7:0] exp_rst(input int i);
        logic [7:0] t [NR] = '{8'h00, 8'hE0, 8'h7F, 8'hF7, 8'hFF, 8'h00, 8'h08, 8'h40,
                               8'h00, 8'h1F, 8'h04, 8'h00, 8'h00, 8'h00, 8'h04};
        return t[i];
    endfunction

    function automatic string req_of(input logic [7:0] idx);
        if (idx >= 8'd15) return "R12";
        if (idx == 8'd11 || idx == 8'd12) return "R7";
        if (idx == 8'd1 || idx == 8'd2) return "R8";
        if (idx == 8'd5 || idx == 8'd6) return "R9";
        return "R2";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ok, a;
        logic [7:0] rd;
        tick(5); rst_n = 1'b1; tick(4);

        // R6: reset contents and released SDA
        for (int i = 0; i < NR; i++) check("R6", "reset byte", cfg[i*8 +: 8], exp_rst(i));
        check("R6", "sda released", {7'b0, sda_oe}, 8'h00);

        // R1: foreign address is refused and stores nothing
        bus_start;
        send_byte(8'hA0, 0, -1, 8'h00, a); check("R1", "foreign addr ack", {7'b0, a}, 8'h00);
        send_byte(8'h80, 0, -1, 8'h00, a); check("R1", "cmd after nack", {7'b0, a}, 8'h00);
        send_byte(8'h5A, 0, -1, 8'h00, a);
        bus_stop;
        check("R1", "reg0 untouched", cfg[7:0], 8'h00);

        // vector table: single-register write then read
        for (int v = 0; v < 11; v++) begin
            logic [7:0] idx, wd, er, ec;
            {idx, wd, er, ec} = VEC[v];
            reg_write(idx, wd, 0, -1, 8'h00, ok);
            check(req_of(idx), "write acks", {7'b0, ok}, 8'h01);
            if (idx < 8'd15) check(req_of(idx), "stored byte", cfg[idx*8 +: 8], ec);
            reg_read(idx, rd);
            check(req_of(idx), "read byte", rd, er);
        end

        // R5: nonzero command without bit 7 is refused
        bus_start;
        send_byte(8'hD2, 0, -1, 8'h00, a);
        send_byte(8'h05, 0, -1, 8'h00, a); check("R5", "bad cmd ack", {7'b0, a}, 8'h00);
        send_byte(8'h00, 0, -1, 8'h00, a);
        bus_stop;
        check("R5", "reg0 kept", cfg[7:0], 8'hA5);
        check("R5", "reg5 kept", cfg[47:40], 8'hDF);

        // R3: block write
        bus_start;
        ok = 1;
        send_byte(8'hD2, 0, -1, 8'h00, a); ok &= a;
        send_byte(8'h00, 0, -1, 8'h00, a); ok &= a;
        send_byte(8'h03, 0, -1, 8'h00, a); ok &= a;
        send_byte(8'h11, 0, -1, 8'h00, a); ok &= a;
        send_byte(8'h22, 0, -1, 8'h00, a); ok &= a;
        send_byte(8'h33, 0, -1, 8'h00, a); ok &= a;
        bus_stop;
        check("R3", "block write acks", {7'b0, ok}, 8'h01);
        check("R3", "block reg0", cfg[7:0], 8'h11);
        check("R3", "block reg1", cfg[15:8], 8'h20);
        check("R3", "block reg2", cfg[23:16], 8'h33);

        // R4: block read, count first then registers from 0
        bus_start;
        send_byte(8'hD2, 0, -1, 8'h00, a);
        send_byte(8'h00, 0, -1, 8'h00, a);
        bus_start;
        send_byte(8'hD3, 0, -1, 8'h00, a);
        recv_byte(1'b0, rd); check("R4", "count", rd, 8'd15);
        recv_byte(1'b0, rd); check("R4", "reg0", rd, 8'h11);
        recv_byte(1'b0, rd); check("R4", "reg1", rd, 8'h35);
        recv_byte(1'b0, rd); check("R4", "reg2", rd, 8'hB3);
        recv_byte(1'b1, rd); check("R4", "reg3", rd, 8'h3C);
        bus_stop;

        // R10: short SCL glitch inside a data bit
        reg_write(8'd8, 8'h5A, 1, -1, 8'h00, ok);
        check("R10", "glitch write acks", {7'b0, ok}, 8'h01);
        check("R10", "glitch write value", cfg[71:64], 8'h5A);

        // R9: wd_count moves across the cycle where the reg6 write lands
        for (int off = 0; off < 10; off++) begin
            reg_write(8'd6, 8'h60 + 8'(off), 0, off, 8'h40 + 8'(off), ok);
            check("R9", "reload stored", cfg[55:48], 8'h60 + 8'(off));
            reg_read(8'd6, rd);
            check("R9", "live count", rd, 8'h40 + 8'(off));
        end
        wd_expired = 1'b1;
        reg_read(8'd5, rd);
        check("R9", "expiry bit", rd, 8'hFF);

        check("R11", "pull-down changes with SCL high", 8'(viol), 8'h00);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule